// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block sits in front of a synchronous memory array. It captures an external address when an access cycle begins and then produces the address of each later access in a four-beat burst, so the controller presents only one address per burst. A cycle can begin from either of two active-low strobes. The processor strobe has priority and is gated by the master chip enable. The controller strobe takes effect only while the processor strobe is idle, and the master enable does not gate it.

Three chip enables are evaluated at each cycle start: an active-low master enable, an active-high enable and an active-low enable. The cycle is marked valid only when all three are active. A controller start with any enable inactive still starts a cycle, and that cycle is a deselect. While a cycle is valid, an active-low advance input steps the two lowest address bits through either an interleaved or a linear order, chosen by a mode input. The upper address bits are never touched.

Top module: `burst_addr_gen`

## Requirements
- R1: While synchronous reset is high, at the next edge `cyc_valid_o` and `from_proc_o` become 0 and `acc_addr_o` becomes 0.
- R2: An edge with `proc_strb_n` low and `en_master_n` low starts a cycle whatever the value of `ctrl_strb_n`. After that edge `acc_addr_o` equals the sampled `addr_i` and `from_proc_o` is 1.
- R3: An edge with `ctrl_strb_n` low and `proc_strb_n` high starts a cycle. After that edge `acc_addr_o` equals the sampled `addr_i` and `from_proc_o` is 0.
- R4: An edge with `proc_strb_n` low and `en_master_n` high changes nothing: the address, `cyc_valid_o` and `from_proc_o` keep their values.
- R5: `en_master_n` high does not block a controller start. The address is loaded and `cyc_valid_o` becomes 0 (deselect).
- R6: After any start, `cyc_valid_o` is 1 only if `en_master_n`=0, `en_hi`=1 and `en_lo_n`=0 were all sampled on the start edge.
- R7: `adv_n` is ignored on an edge that starts a cycle through the processor strobe. The first beat is always the loaded address.
- R8: The burst moves to its next beat only on an edge where `adv_n` is low and both strobes are high. With `adv_n` high, or with either strobe low, it does not advance.
- R9: With `ilv_mode`=1 the low two bits of beat k are (start low bits) XOR k. For example, start 1 gives 1,0,3,2.
- R10: With `ilv_mode`=0 the low two bits of beat k are (start low bits + k) mod 4. For example, start 3 gives 3,0,1,2.
- R11: Bits above bit 1 of `acc_addr_o` stay equal to the loaded address during a burst. After four advances the burst wraps back to the loaded address.
- R12: While `cyc_valid_o` is 0, `adv_n` low has no effect on `acc_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External address captured on a cycle start |
| proc_strb_n | input | 1 | Processor start strobe, active low, gated by master enable |
| ctrl_strb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ilv_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| en_master_n | input | 1 | Master chip enable, active low |
| en_hi | input | 1 | Chip enable, active high |
| en_lo_n | input | 1 | Chip enable, active low |
| acc_addr_o | output | ADDR_W | Address of the current access |
| cyc_valid_o | output | 1 | Current cycle selects the device |
| from_proc_o | output | 1 | Current cycle was started by the processor strobe |

## Verification
The hardest case to reach is the difference between the master enable blocking the processor strobe and leaving the controller strobe free. Each check needs a burst already advanced to a non-zero beat, so that the preserved state can be told apart from a reload. The stimulus first starts a valid burst from a distinct address and advances it. It then applies the processor strobe with the master enable off and the advance input low, and confirms that the address, valid flag and source flag do not move. After that, the controller strobe with the master enable off must reload the address and drop the valid flag.

// File: rtl/burst_pkg.sv
package burst_pkg;
    parameter int BURST_W = 2;
    typedef logic [BURST_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic proc_go;
        logic ctrl_go;
        logic selected;
    } start_t;

    function automatic beat_t map_beat(beat_t first, beat_t step, order_e ord);
        if (ord == ORD_INTERLEAVE) return first ^ step;
        return beat_t'(first + step);
    endfunction
endpackage

// File: rtl/burst_start_decode.sv
module burst_start_decode
    import burst_pkg::*;
(
    input  logic   proc_strb_n,
    input  logic   ctrl_strb_n,
    input  logic   en_master_n,
    input  logic   en_hi,
    input  logic   en_lo_n,
    output start_t start_o
);
    always_comb begin
        start_o.proc_go  = !proc_strb_n && !en_master_n;
        start_o.ctrl_go  = proc_strb_n && !ctrl_strb_n;
        start_o.selected = !en_master_n && en_hi && !en_lo_n;
    end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  step_en,
    output beat_t beat_o
);
    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst || restart) beat_q <= '0;
        else if (step_en)   beat_q <= beat_q + 1'b1;
    end

    assign beat_o = beat_q;
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base_i,
    input  beat_t             beat_i,
    input  order_e            ord_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int HI_W = ADDR_W - BURST_W;

    generate
        if (HI_W > 0) begin : g_upper
            assign addr_o[ADDR_W-1:BURST_W] = base_i[ADDR_W-1:BURST_W];
        end
    endgenerate

    assign addr_o[BURST_W-1:0] = map_beat(base_i[BURST_W-1:0], beat_i, ord_i);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic              ilv_mode,
    input  logic              en_master_n,
    input  logic              en_hi,
    input  logic              en_lo_n,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic              cyc_valid_o,
    output logic              from_proc_o
);
    start_t            st;
    logic              go;
    logic              step_en;
    beat_t             beat;
    logic [ADDR_W-1:0] base_q;
    logic              valid_q;
    logic              proc_q;

    burst_start_decode u_dec (
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .en_master_n (en_master_n),
        .en_hi       (en_hi),
        .en_lo_n     (en_lo_n),
        .start_o     (st)
    );

    assign go      = st.proc_go || st.ctrl_go;
    // Advance only with both strobes idle and a valid cycle open
    assign step_en = proc_strb_n && ctrl_strb_n && !adv_n && valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            valid_q <= 1'b0;
            proc_q  <= 1'b0;
        end else if (go) begin
            base_q  <= addr_i;
            valid_q <= st.selected;
            proc_q  <= st.proc_go;
        end
    end

    burst_beat_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (go),
        .step_en (step_en),
        .beat_o  (beat)
    );

    burst_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .base_i (base_q),
        .beat_i (beat),
        .ord_i  (order_e'(ilv_mode)),
        .addr_o (acc_addr_o)
    );

    assign cyc_valid_o = valid_q;
    assign from_proc_o = proc_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_i,
    input logic              proc_strb_n,
    input logic              ctrl_strb_n,
    input logic              adv_n,
    input logic              en_master_n,
    input logic              en_hi,
    input logic              en_lo_n,
    input logic [ADDR_W-1:0] acc_addr_o,
    input logic              cyc_valid_o,
    input logic              from_proc_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!cyc_valid_o && !from_proc_o && acc_addr_o == '0));

    a_r2_proc_load: assert property (@(posedge clk) disable iff (rst)
        (!proc_strb_n && !en_master_n) |=> (from_proc_o && acc_addr_o == $past(addr_i)));

    a_r3_ctrl_load: assert property (@(posedge clk) disable iff (rst)
        (proc_strb_n && !ctrl_strb_n) |=> (!from_proc_o && acc_addr_o == $past(addr_i)));

    a_r4_master_blocks_proc: assert property (@(posedge clk) disable iff (rst)
        (!proc_strb_n && en_master_n) |=> ($stable(cyc_valid_o) && $stable(from_proc_o)));

    a_r6_select_rule: assert property (@(posedge clk) disable iff (rst)
        ((!proc_strb_n && !en_master_n) || (proc_strb_n && !ctrl_strb_n))
        |=> (cyc_valid_o == $past(!en_master_n && en_hi && !en_lo_n)));

    a_r8_idle_holds_flags: assert property (@(posedge clk) disable iff (rst)
        (proc_strb_n && ctrl_strb_n) |=> ($stable(cyc_valid_o) && $stable(from_proc_o)));

    a_r11_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        (proc_strb_n && ctrl_strb_n) |=> $stable(acc_addr_o[ADDR_W-1:2]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (addr_i),
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .adv_n       (adv_n),
    .en_master_n (en_master_n),
    .en_hi       (en_hi),
    .en_lo_n     (en_lo_n),
    .acc_addr_o  (acc_addr_o),
    .cyc_valid_o (cyc_valid_o),
    .from_proc_o (from_proc_o)
);

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic          proc_strb_n, ctrl_strb_n, adv_n, ilv_mode;
    logic          en_master_n, en_hi, en_lo_n;
    logic [AW-1:0] acc_addr_o;
    logic          cyc_valid_o, from_proc_o;
    int            checks = 0;
    int            errors = 0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .addr_i(addr_i),
        .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
        .ilv_mode(ilv_mode), .en_master_n(en_master_n), .en_hi(en_hi),
        .en_lo_n(en_lo_n), .acc_addr_o(acc_addr_o), .cyc_valid_o(cyc_valid_o),
        .from_proc_o(from_proc_o)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic idle();
        proc_strb_n = 1; ctrl_strb_n = 1; adv_n = 1;
        en_master_n = 0; en_hi = 1; en_lo_n = 0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic proc_start(logic [AW-1:0] a, logic adv);
        addr_i = a; proc_strb_n = 0; adv_n = adv;
        tick();
        proc_strb_n = 1; adv_n = 1;
    endtask

    task automatic ctrl_start(logic [AW-1:0] a);
        addr_i = a; ctrl_strb_n = 0;
        tick();
        ctrl_strb_n = 1;
    endtask

    task automatic advance();
        adv_n = 0; tick(); adv_n = 1;
    endtask

    task automatic t_reset();
        rst = 1; idle(); addr_i = '0; ilv_mode = 1;
        tick(); tick();
        chk("R1 valid", cyc_valid_o, 0);
        chk("R1 src", from_proc_o, 0);
        chk("R1 addr", acc_addr_o, 0);
        rst = 0;
    endtask

    task automatic t_interleave();
        logic [1:0] seq [4] = '{2'd1, 2'd0, 2'd3, 2'd2};
        ilv_mode = 1; idle();
        ctrl_strb_n = 0;
        proc_start(20'hABCD1, 1'b1);
        ctrl_strb_n = 1;
        chk("R2 addr", acc_addr_o, 20'hABCD1);
        chk("R2 src", from_proc_o, 1);
        chk("R6 valid", cyc_valid_o, 1);
        for (int k = 1; k < 4; k++) begin
            advance();
            chk("R9 beat", acc_addr_o, {18'(20'hABCD1 >> 2), seq[k]});
            chk("R11 upper", acc_addr_o[AW-1:2], 18'(20'hABCD1 >> 2));
        end
        advance();
        chk("R11 wrap", acc_addr_o, 20'hABCD1);
    endtask

    task automatic t_linear();
        logic [1:0] seq [4] = '{2'd3, 2'd0, 2'd1, 2'd2};
        ilv_mode = 0; idle();
        proc_start(20'h12347, 1'b0);
        chk("R7 adv ignored", acc_addr_o, 20'h12347);
        for (int k = 1; k < 4; k++) begin
            advance();
            chk("R10 beat", acc_addr_o, {18'(20'h12347 >> 2), seq[k]});
        end
        advance();
        chk("R11 wrap", acc_addr_o, 20'h12347);
    endtask

    task automatic t_hold();
        ilv_mode = 0; idle();
        proc_start(20'h00010, 1'b1);
        advance();
        chk("R8 step", acc_addr_o, 20'h00011);
        tick(); tick();
        chk("R8 adv high holds", acc_addr_o, 20'h00011);
        addr_i = 20'h55555; proc_strb_n = 0; en_master_n = 1; adv_n = 0;
        tick();
        idle();
        chk("R4 addr kept", acc_addr_o, 20'h00011);
        chk("R4 valid kept", cyc_valid_o, 1);
        chk("R4 src kept", from_proc_o, 1);
        chk("R8 strobe low no step", acc_addr_o, 20'h00011);
    endtask

    task automatic t_ctrl();
        ilv_mode = 1; idle();
        ctrl_start(20'h0F0F2);
        chk("R3 addr", acc_addr_o, 20'h0F0F2);
        chk("R3 src", from_proc_o, 0);
        chk("R6 ctrl valid", cyc_valid_o, 1);
        advance();
        chk("R9 ctrl beat", acc_addr_o, 20'h0F0F3);
        en_master_n = 1;
        ctrl_start(20'h33330);
        idle();
        chk("R5 addr", acc_addr_o, 20'h33330);
        chk("R5 deselect", cyc_valid_o, 0);
        advance();
        chk("R12 idle adv", acc_addr_o, 20'h33330);
    endtask

    task automatic t_select();
        idle(); en_hi = 0;
        proc_start(20'h44444, 1'b1);
        chk("R6 en_hi low", cyc_valid_o, 0);
        idle(); en_lo_n = 1;
        ctrl_start(20'h44448);
        chk("R6 en_lo_n high", cyc_valid_o, 0);
        idle();
        proc_start(20'h44448, 1'b1);
        chk("R6 all active", cyc_valid_o, 1);
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_interleave();
        t_linear();
        t_hold();
        t_ctrl();
        t_select();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule